// File: doc/BRIEF.md
# JTAG Instruction Register and Decoder

This block holds the instruction register of a test access port and turns the
active instruction into the path-select and control lines that the rest of the
test logic needs. The TAP state machine, which sits outside this block, drives it
with one-cycle strobes for Capture-IR, Shift-IR, Update-IR, Capture-DR and
Shift-DR, and with a test-logic-reset level. A 5-bit shift stage takes in the new
opcode least significant bit first. The opcode is copied into the active
instruction only on Update-IR. A decoder then registers the control outputs in
that same update.

The outputs choose a serial path: the one-bit bypass register, the boundary scan
chain, or one of several auxiliary TAP controllers. They also give a pin-drive
enable for the boundary cells and an internal system-reset request. Every opcode
without a defined meaning selects the bypass path. This includes the codes kept
for factory debug. The one-bit bypass register is also part of this block. It
shifts only while it is the selected path.

Top module: `jtag_ir_decoder`

## Requirements
- R1: A synchronous `rst` or an asserted `tlr` sets the active instruction to 5'b11111 (bypass) at the next clock edge. In the same edge the decoded outputs become: bypass path selected, no boundary path, no pin drive, no system reset and no auxiliary select.
- R2: A `capture_ir` strobe loads 5'b00001 into the shift stage, and `ir_tdo` then shows bit 0 of the shift stage.
- R3: A `shift_ir` strobe moves the shift stage one place toward bit 0 and loads `tdi` into bit 4. `ir_tdo` always shows bit 0, so an opcode goes in least significant bit first.
- R4: `active_ir` and all decoded outputs change only on `update_ir`, `rst` or `tlr`. An update copies the shift stage into `active_ir` and the outputs in the same clock edge.
- R5: Opcode 5'b00000 (external test) selects the boundary path and asserts `bscan_drive` and `sys_rst_req`.
- R6: Opcode 5'b00010 (sample/preload) selects the boundary path with no pin drive and no system reset.
- R7: Opcode 5'b01100 (clamp) selects the bypass path and asserts `bscan_drive` and `sys_rst_req`.
- R8: Opcode 5'b11111 (bypass) selects the bypass path only, with no drive, no reset and no auxiliary select.
- R9: Opcodes 5'b10000 to 5'b10011 each raise one bit of `aux_sel`: the opcode minus 5'b10000 gives the bit index. Neither the bypass nor the boundary path is selected, and there is no drive and no reset.
- R10: Every other opcode, including 5'b00101, 5'b00110 and 5'b01010, decodes exactly as bypass.
- R11: While the bypass path is selected, `capture_dr` clears the bypass bit and `shift_dr` loads `tdi` into it. While the bypass path is not selected, the bit holds its value. `byp_tdo` shows the bit, and `rst` or `tlr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| capture_ir | input | 1 | Capture-IR strobe |
| shift_ir | input | 1 | Shift-IR strobe |
| update_ir | input | 1 | Update-IR strobe |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| tdi | input | 1 | Serial test data in |
| ir_tdo | output | 1 | Serial out of the instruction shift stage |
| byp_tdo | output | 1 | Serial out of the bypass bit |
| active_ir | output | 5 | Active instruction |
| sel_bscan | output | 1 | Boundary scan chain is the serial path |
| sel_bypass | output | 1 | Bypass bit is the serial path |
| bscan_drive | output | 1 | Boundary cells drive the output pins |
| sys_rst_req | output | 1 | Internal system reset request |
| aux_sel | output | 4 | One-hot auxiliary TAP select |

## Verification
The hardest state to reach from the ports is a full sweep of the opcode space. That sweep has to include the codes kept for factory debug and the codes next to the auxiliary range. Every opcode can only enter through five serial shifts and then an update. The bench does this for all 32 values. After each one it runs a Capture-DR and Shift-DR burst, so the bypass bit is seen both moving and holding. A test-logic reset is sent halfway through the sweep, and an update with no shift is used to reach the captured pattern itself.

// File: rtl/jir_pkg.sv
package jir_pkg;
  typedef struct packed {
    logic path_bscan;
    logic path_bypass;
    logic pin_drive;
    logic sys_rst;
  } jir_ctl_t;

  localparam jir_ctl_t CTL_BYPASS = '{path_bscan: 1'b0, path_bypass: 1'b1,
                                      pin_drive: 1'b0, sys_rst: 1'b0};
endpackage

// File: rtl/jir_decode.sv
module jir_decode
  import jir_pkg::*;
#(
  parameter int IR_W = 5,
  parameter int NAUX = 4,
  parameter logic [IR_W-1:0] OP_EXTEST   = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 5'b00010,
  parameter logic [IR_W-1:0] OP_CLAMP    = 5'b01100,
  parameter logic [IR_W-1:0] OP_BYPASS   = 5'b11111,
  parameter logic [IR_W-1:0] OP_AUX_BASE = 5'b10000
) (
  input  logic [IR_W-1:0] opcode,
  output jir_ctl_t        ctl,
  output logic [NAUX-1:0] aux_hit
);
  // one comparator per auxiliary controller, contiguous opcodes
  for (genvar g = 0; g < NAUX; g++) begin : g_aux
    localparam logic [IR_W-1:0] AUX_OP = OP_AUX_BASE + IR_W'(g);
    assign aux_hit[g] = (opcode == AUX_OP);
  end

  always_comb begin
    ctl = CTL_BYPASS;
    if (|aux_hit) begin
      ctl = '0;
    end else if (opcode == OP_EXTEST) begin
      ctl = '{path_bscan: 1'b1, path_bypass: 1'b0, pin_drive: 1'b1, sys_rst: 1'b1};
    end else if (opcode == OP_SAMPLE) begin
      ctl = '{path_bscan: 1'b1, path_bypass: 1'b0, pin_drive: 1'b0, sys_rst: 1'b0};
    end else if (opcode == OP_CLAMP) begin
      ctl = '{path_bscan: 1'b0, path_bypass: 1'b1, pin_drive: 1'b1, sys_rst: 1'b1};
    end else if (opcode == OP_BYPASS) begin
      ctl = CTL_BYPASS;
    end
  end
endmodule

// File: rtl/jir_ir_shift.sv
module jir_ir_shift #(
  parameter int IR_W = 5,
  parameter logic [IR_W-1:0] CAP_PAT = 5'b00001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tlr,
  input  logic            capture,
  input  logic            shift,
  input  logic            tdi,
  output logic [IR_W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst || tlr) begin
      sr <= CAP_PAT;
    end else if (capture) begin
      sr <= CAP_PAT;
    end else if (shift) begin
      sr <= {tdi, sr[IR_W-1:1]};
    end
  end

  AST_CAPTURE_PAT: assert property (@(posedge clk) disable iff (rst)
    (capture && !tlr) |=> (sr == CAP_PAT)); // R2
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (shift && !capture && !tlr) |=> (sr[IR_W-1] == $past(tdi))); // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (shift && !capture && !tlr) |=> (sr[IR_W-2:0] == $past(sr[IR_W-1:1]))); // R3
endmodule

// File: rtl/jir_ir_hold.sv
module jir_ir_hold
  import jir_pkg::*;
#(
  parameter int IR_W = 5,
  parameter int NAUX = 4,
  parameter logic [IR_W-1:0] OP_EXTEST   = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 5'b00010,
  parameter logic [IR_W-1:0] OP_CLAMP    = 5'b01100,
  parameter logic [IR_W-1:0] OP_BYPASS   = 5'b11111,
  parameter logic [IR_W-1:0] OP_AUX_BASE = 5'b10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tlr,
  input  logic            update,
  input  logic [IR_W-1:0] sr,
  output logic [IR_W-1:0] act_q,
  output jir_ctl_t        ctl_q,
  output logic [NAUX-1:0] aux_q
);
  jir_ctl_t        ctl_d;
  logic [NAUX-1:0] aux_d;

  // decode the shift stage so outputs are registered with the opcode
  jir_decode #(
    .IR_W(IR_W), .NAUX(NAUX), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_CLAMP(OP_CLAMP), .OP_BYPASS(OP_BYPASS), .OP_AUX_BASE(OP_AUX_BASE)
  ) u_dec (
    .opcode (sr),
    .ctl    (ctl_d),
    .aux_hit(aux_d)
  );

  always_ff @(posedge clk) begin
    if (rst || tlr) begin
      act_q <= OP_BYPASS;
      ctl_q <= CTL_BYPASS;
      aux_q <= '0;
    end else if (update) begin
      act_q <= sr;
      ctl_q <= ctl_d;
      aux_q <= aux_d;
    end
  end

  AST_TLR_BYPASS: assert property (@(posedge clk) disable iff (rst)
    tlr |=> (act_q == OP_BYPASS && ctl_q.path_bypass && aux_q == '0)); // R1
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!update && !tlr) |=> ($stable(act_q) && $stable(ctl_q) && $stable(aux_q))); // R4
  AST_AUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(aux_q)); // R9
  AST_AUX_NO_PATH: assert property (@(posedge clk) disable iff (rst)
    (aux_q != '0) |-> (!ctl_q.path_bscan && !ctl_q.path_bypass)); // R9
  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ctl_q.path_bscan && ctl_q.path_bypass)); // R8
  AST_RST_DRIVES: assert property (@(posedge clk) disable iff (rst)
    ctl_q.sys_rst |-> ctl_q.pin_drive); // R7
endmodule

// File: rtl/jir_bypass.sv
module jir_bypass (
  input  logic clk,
  input  logic rst,
  input  logic tlr,
  input  logic en,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || tlr) begin
      q <= 1'b0;
    end else if (en && capture) begin
      q <= 1'b0;
    end else if (en && shift) begin
      q <= tdi;
    end
  end

  AST_BYP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (en && capture) |=> !q); // R11
  AST_BYP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !tlr) |=> $stable(q)); // R11
endmodule

// File: rtl/jtag_ir_decoder.sv
module jtag_ir_decoder
  import jir_pkg::*;
#(
  parameter int IR_W = 5,
  parameter int NAUX = 4,
  parameter logic [IR_W-1:0] CAP_PAT     = 5'b00001,
  parameter logic [IR_W-1:0] OP_EXTEST   = 5'b00000,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 5'b00010,
  parameter logic [IR_W-1:0] OP_CLAMP    = 5'b01100,
  parameter logic [IR_W-1:0] OP_BYPASS   = 5'b11111,
  parameter logic [IR_W-1:0] OP_AUX_BASE = 5'b10000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tlr,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            tdi,
  output logic            ir_tdo,
  output logic            byp_tdo,
  output logic [IR_W-1:0] active_ir,
  output logic            sel_bscan,
  output logic            sel_bypass,
  output logic            bscan_drive,
  output logic            sys_rst_req,
  output logic [NAUX-1:0] aux_sel
);
  logic [IR_W-1:0] sr;
  jir_ctl_t        ctl;

  jir_ir_shift #(.IR_W(IR_W), .CAP_PAT(CAP_PAT)) u_shift (
    .clk(clk), .rst(rst), .tlr(tlr), .capture(capture_ir),
    .shift(shift_ir), .tdi(tdi), .sr(sr)
  );

  jir_ir_hold #(
    .IR_W(IR_W), .NAUX(NAUX), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_CLAMP(OP_CLAMP), .OP_BYPASS(OP_BYPASS), .OP_AUX_BASE(OP_AUX_BASE)
  ) u_hold (
    .clk(clk), .rst(rst), .tlr(tlr), .update(update_ir), .sr(sr),
    .act_q(active_ir), .ctl_q(ctl), .aux_q(aux_sel)
  );

  jir_bypass u_byp (
    .clk(clk), .rst(rst), .tlr(tlr), .en(ctl.path_bypass),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi), .q(byp_tdo)
  );

  assign ir_tdo      = sr[0];
  assign sel_bscan   = ctl.path_bscan;
  assign sel_bypass  = ctl.path_bypass;
  assign bscan_drive = ctl.pin_drive;
  assign sys_rst_req = ctl.sys_rst;
endmodule

// File: tb/jtag_ir_decoder_tb_top.sv
module jtag_ir_decoder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst, tlr, capture_ir, shift_ir, update_ir, capture_dr, shift_dr, tdi;
  logic       ir_tdo, byp_tdo, sel_bscan, sel_bypass, bscan_drive, sys_rst_req;
  logic [4:0] active_ir;
  logic [3:0] aux_sel;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_ir_decoder dut_i (
    .clk(clk), .rst(rst), .tlr(tlr), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
    .ir_tdo(ir_tdo), .byp_tdo(byp_tdo), .active_ir(active_ir), .sel_bscan(sel_bscan),
    .sel_bypass(sel_bypass), .bscan_drive(bscan_drive), .sys_rst_req(sys_rst_req),
    .aux_sel(aux_sel)
  );

  // reference model state
  int   m_sr  = 1;
  int   m_act = 31;
  bit   m_byp = 1'b0;
  bit   m_was_rst = 1'b1;

  // returns {bscan, bypass, drive, sysrst, aux[3:0]}
  function automatic logic [7:0] exp_dec(input int op);
    if (op >= 16 && op <= 19) return {4'b0000, 4'(1 << (op - 16))};
    if (op == 0)  return 8'b1011_0000;
    if (op == 2)  return 8'b1000_0000;
    if (op == 12) return 8'b0111_0000;
    return 8'b0100_0000;
  endfunction

  function automatic string dec_tag(input int op);
    if (m_was_rst) return "R1";
    if (op == 0)  return "R5";
    if (op == 2)  return "R6";
    if (op == 12) return "R7";
    if (op == 31) return "R8";
    if (op >= 16 && op <= 19) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (rst || tlr) begin
      m_sr = 1; m_act = 31; m_byp = 1'b0; m_was_rst = 1'b1;
    end else begin
      logic [7:0] d;
      d = exp_dec(m_act);
      if (d[6]) begin
        if (capture_dr) m_byp = 1'b0;
        else if (shift_dr) m_byp = tdi;
      end
      if (update_ir) begin m_act = m_sr; m_was_rst = 1'b0; end
      if (capture_ir) m_sr = 1;
      else if (shift_ir) m_sr = (m_sr >> 1) | (int'(tdi) << 4);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R4", {3'b0, active_ir}, 8'(m_act));
    chk("R2/R3", {7'b0, ir_tdo}, {7'b0, m_sr[0]});
    chk(dec_tag(m_act), {sel_bscan, sel_bypass, bscan_drive, sys_rst_req, aux_sel},
        exp_dec(m_act));
    chk("R11", {7'b0, byp_tdo}, {7'b0, m_byp});
  endtask

  task automatic cyc(input bit ci, input bit si, input bit ui, input bit cd,
                     input bit sd, input bit t, input bit d);
    capture_ir = ci; shift_ir = si; update_ir = ui;
    capture_dr = cd; shift_dr = sd; tlr = t; tdi = d;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic load_ir(input int code);
    cyc(1, 0, 0, 0, 0, 0, 0);                       // R2 capture
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0, code[i]); // R3 shift
    cyc(0, 0, 0, 0, 0, 0, 1'b1);                    // R4 idle, no change
    cyc(0, 0, 1, 0, 0, 0, 0);                       // R4 update
  endtask

  task automatic dr_burst(input logic [3:0] pat);
    cyc(0, 0, 0, 1, 0, 0, 1'b1);                    // R11 capture clears
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0, pat[i]);
  endtask

  initial begin
    rst = 1'b1; tlr = 1'b0; capture_ir = 0; shift_ir = 0; update_ir = 0;
    capture_dr = 0; shift_dr = 0; tdi = 0;
    @(negedge clk);
    repeat (3) begin @(posedge clk); @(negedge clk); end
    rst = 1'b0;
    compare();                                       // R1 reset state
    dr_burst(4'b1011);                               // R11 bypass after reset
    for (int code = 0; code < 32; code++) begin      // R5..R10 full sweep
      load_ir(code);
      dr_burst(4'(code) ^ 4'b0110);
      if (code == 12) begin
        cyc(0, 0, 0, 0, 0, 1, 0);                    // R1 test-logic reset
        dr_burst(4'b1101);
      end
    end
    cyc(1, 0, 0, 0, 0, 0, 0);                        // R2 update with no shift
    cyc(0, 0, 1, 0, 0, 0, 0);                        // R10 5'b00001
    dr_burst(4'b0101);
    load_ir(17);                                     // R9 then capture: hold
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule